// File: doc/BRIEF.md
# Event-Driven Dual State Register

This block keeps two small state registers, called low and high, and changes them when events fire. Each clock cycle it receives a vector of event-fire flags and one control word per event. The control word says which register the event acts on, whether the event replaces the register or adds to it, and the operand.

For each register, the firing event with the highest number that targets it chooses the update. Every other firing event aimed at that register is ignored. The two registers are arbitrated separately in the same cycle. A unified-mode input sends every event to the low register. In that mode the high register keeps its value.

The block sits next to the event-evaluation logic of a timer. That logic produces the fire vector and reads the state outputs back to qualify later events.

Top module: `evt_state_update`

## Requirements
- R1: A synchronous reset sets both the low and the high state register to 0, even when events fire in the same cycle.
- R2: In a cycle where no event fires, both state registers keep their values.
- R3: Bit 4 of an event's control word selects its target register: 0 selects low and 1 selects high. An event changes only the register it targets.
- R4: When bit 14 (load) of the winning event's control word is 1, the target register takes the 5-bit operand held in bits 19:15.
- R5: When the load bit is 0, the operand in bits 19:15 is added to the target register modulo 32, and the carry is discarded.
- R6: An event whose load bit is 0 and whose operand is 0 leaves its target register unchanged.
- R7: When several events that target the same register fire in one cycle, only the highest-numbered one acts. Lower-numbered ones have no effect.
- R8: The low and high registers are arbitrated independently. Each one takes the update of its own winning event in the same cycle.
- R9: When `unify_i` is 1, every event targets the low register whatever its bit 4, and the high register holds its value.
- R10: A register changes on the first rising clock edge at which the firing event is sampled, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| unify_i | input | 1 | When set, all events act on the low register |
| fire_i | input | 16 | One fire flag per event; bit n is event n |
| ctrl_i | input | 16*32 | Control words; event n occupies bits 32n+31:32n |
| state_lo_o | output | 5 | Low state register |
| state_hi_o | output | 5 | High state register |

## Verification
The hardest case to reach is a single cycle in which many events fire at once with mixed targets and mixed operations. In that case the low and high winners must be found independently, and no lower-numbered event may leak into the result. The stimulus builds such cycles directly. A loading event sits below an adding event of higher number, and vice versa, so that a wrong pick gives a different value. Unified mode is then driven with a high-numbered event whose select bit points to the high register, which shows both the redirect and that the high register holds.

// File: rtl/evt_state_pkg.sv
package evt_state_pkg;
   // Control word layout; field positions are shared with the event decoder.
   localparam int CTRL_W   = 32;
   localparam int SEL_BIT  = 4;
   localparam int LOAD_BIT = 14;
   localparam int VAL_LSB  = 15;
   localparam int VAL_W    = 5;

   typedef enum logic {TGT_LO = 1'b0, TGT_HI = 1'b1} tgt_e;
endpackage

// File: rtl/evt_cfg_decode.sv
module evt_cfg_decode
   import evt_state_pkg::*;
#(
   parameter int NUM_EVT = 16
) (
   input  logic [NUM_EVT*CTRL_W-1:0] ctrl_i,
   input  logic                      unify_i,
   output logic [NUM_EVT-1:0]        tgt_hi_o,
   output logic [NUM_EVT-1:0]        load_o,
   output logic [NUM_EVT*VAL_W-1:0]  val_o
);
   for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
      logic [CTRL_W-1:0] word;
      assign word                   = ctrl_i[e*CTRL_W +: CTRL_W];
      assign tgt_hi_o[e]            = word[SEL_BIT] & ~unify_i;
      assign load_o[e]              = word[LOAD_BIT];
      assign val_o[e*VAL_W +: VAL_W] = word[VAL_LSB +: VAL_W];
   end
endmodule

// File: rtl/evt_prio_pick.sv
module evt_prio_pick
   import evt_state_pkg::*;
#(
   parameter int   NUM_EVT = 16,
   parameter tgt_e TARGET  = TGT_LO
) (
   input  logic [NUM_EVT-1:0]       fire_i,
   input  logic [NUM_EVT-1:0]       tgt_hi_i,
   input  logic [NUM_EVT-1:0]       load_i,
   input  logic [NUM_EVT*VAL_W-1:0] val_i,
   output logic                     hit_o,
   output logic                     load_o,
   output logic [VAL_W-1:0]         val_o
);
   // Ascending scan: a later (higher-numbered) match overrides earlier ones.
   always_comb begin
      hit_o  = 1'b0;
      load_o = 1'b0;
      val_o  = '0;
      for (int e = 0; e < NUM_EVT; e++) begin
         if (fire_i[e] && (tgt_hi_i[e] == logic'(TARGET))) begin
            hit_o  = 1'b1;
            load_o = load_i[e];
            val_o  = val_i[e*VAL_W +: VAL_W];
         end
      end
   end
endmodule

// File: rtl/evt_state_reg.sv
module evt_state_reg #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         hit_i,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk) begin
      if (rst)
         q_o <= '0;
      else if (hit_i)
         q_o <= load_i ? val_i : W'(q_o + val_i);
   end
endmodule

// File: rtl/evt_state_update.sv
module evt_state_update
   import evt_state_pkg::*;
#(
   parameter int NUM_EVT = 16,
   parameter int STATE_W = 5
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      unify_i,
   input  logic [NUM_EVT-1:0]        fire_i,
   input  logic [NUM_EVT*CTRL_W-1:0] ctrl_i,
   output logic [STATE_W-1:0]        state_lo_o,
   output logic [STATE_W-1:0]        state_hi_o
);
   localparam int NUM_TGT = 2;

   if (NUM_EVT < 1) begin : g_bad_evt
      $error("NUM_EVT must be at least 1");
   end
   if (STATE_W != VAL_W) begin : g_bad_w
      $error("STATE_W must equal the control-word operand width");
   end

   logic [NUM_EVT-1:0]       tgt_hi, load;
   logic [NUM_EVT*VAL_W-1:0] val;

   evt_cfg_decode #(.NUM_EVT(NUM_EVT)) u_dec (
      .ctrl_i  (ctrl_i),
      .unify_i (unify_i),
      .tgt_hi_o(tgt_hi),
      .load_o  (load),
      .val_o   (val)
   );

   logic [NUM_TGT-1:0]       hit, ld;
   logic [NUM_TGT*VAL_W-1:0] v;
   logic [NUM_TGT*STATE_W-1:0] q;

   for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
      evt_prio_pick #(.NUM_EVT(NUM_EVT), .TARGET(tgt_e'(t))) u_pick (
         .fire_i  (fire_i),
         .tgt_hi_i(tgt_hi),
         .load_i  (load),
         .val_i   (val),
         .hit_o   (hit[t]),
         .load_o  (ld[t]),
         .val_o   (v[t*VAL_W +: VAL_W])
      );
      evt_state_reg #(.W(STATE_W)) u_reg (
         .clk   (clk),
         .rst   (rst),
         .hit_i (hit[t]),
         .load_i(ld[t]),
         .val_i (v[t*VAL_W +: STATE_W]),
         .q_o   (q[t*STATE_W +: STATE_W])
      );
   end

   assign state_lo_o = q[0 +: STATE_W];
   assign state_hi_o = q[STATE_W +: STATE_W];
endmodule

// File: rtl/evt_state_update_chk.sv
module evt_state_update_chk
   import evt_state_pkg::*;
#(
   parameter int NUM_EVT = 16,
   parameter int STATE_W = 5
) (
   input logic                      clk,
   input logic                      rst,
   input logic                      unify_i,
   input logic [NUM_EVT-1:0]        fire_i,
   input logic [NUM_EVT*CTRL_W-1:0] ctrl_i,
   input logic [STATE_W-1:0]        state_lo_o,
   input logic [STATE_W-1:0]        state_hi_o
);
   localparam int TOP = NUM_EVT - 1;
   logic [CTRL_W-1:0] top_w;
   logic              top_lo;
   assign top_w  = ctrl_i[TOP*CTRL_W +: CTRL_W];
   assign top_lo = fire_i[TOP] && (unify_i || !top_w[SEL_BIT]);

   AST_RESET_ZERO: assert property (@(posedge clk)
      rst |=> (state_lo_o == '0 && state_hi_o == '0)); // R1
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (fire_i == '0) |=> ($stable(state_lo_o) && $stable(state_hi_o))); // R2
   AST_UNIFY_HI_HOLD: assert property (@(posedge clk) disable iff (rst)
      unify_i |=> $stable(state_hi_o)); // R9
   AST_TOP_LOAD: assert property (@(posedge clk) disable iff (rst)
      (top_lo && top_w[LOAD_BIT]) |=>
         (state_lo_o == $past(top_w[VAL_LSB +: STATE_W]))); // R4
   AST_TOP_ADD: assert property (@(posedge clk) disable iff (rst)
      (top_lo && !top_w[LOAD_BIT]) |=>
         (state_lo_o == STATE_W'($past(state_lo_o) + $past(top_w[VAL_LSB +: STATE_W])))); // R5
endmodule

bind evt_state_update evt_state_update_chk #(.NUM_EVT(NUM_EVT), .STATE_W(STATE_W)) u_chk (.*);

// File: tb/sim_evt_state_update.sv
`timescale 1ns/1ps
module sim_evt_state_update;
   localparam int N = 16;
   logic clk = 1'b0, rst = 1'b1, unify = 1'b0;
   logic [N-1:0] fire = '0;
   logic [31:0] cfg [N];
   logic [N*32-1:0] ctrl;
   logic [4:0] lo, hi;
   int errors = 0, checks = 0;
   bit done = 0;

   always #2 clk = ~clk;

   always_comb
      for (int i = 0; i < N; i++) ctrl[i*32 +: 32] = cfg[i];

   evt_state_update u0 (.clk(clk), .rst(rst), .unify_i(unify), .fire_i(fire),
                        .ctrl_i(ctrl), .state_lo_o(lo), .state_hi_o(hi));

   function automatic logic [31:0] mk(input bit sel, input bit ld, input logic [4:0] v);
      logic [31:0] w = '0;
      w[4] = sel; w[14] = ld; w[19:15] = v;
      return w;
   endfunction

   task automatic chk(input string req, input logic [4:0] exp_lo, input logic [4:0] exp_hi);
      checks++;
      if (lo !== exp_lo || hi !== exp_hi) begin
         errors++;
         $display("FAIL %s: lo=%0d hi=%0d expected lo=%0d hi=%0d", req, lo, hi, exp_lo, exp_hi);
      end
   endtask

   task automatic step(input logic [N-1:0] f);
      @(negedge clk); fire = f;
      @(posedge clk); #1; fire = '0;
   endtask

   task automatic t_reset;
      chk("R1 reset", 5'd0, 5'd0);
   endtask

   task automatic t_load_sel;
      cfg[3] = mk(0, 1, 5'd9);  cfg[5] = mk(1, 1, 5'd20);
      step(16'h0008); chk("R4 load low", 5'd9, 5'd0);
      step(16'h0020); chk("R3 select high", 5'd9, 5'd20);
   endtask

   task automatic t_add;
      cfg[2] = mk(0, 0, 5'd30);
      step(16'h0004); chk("R5 add wrap", 5'd7, 5'd20);
      cfg[2] = mk(0, 0, 5'd0);
      step(16'h0004); chk("R6 add zero", 5'd7, 5'd20);
      step(16'h0000); chk("R2 idle hold", 5'd7, 5'd20);
   endtask

   task automatic t_prio;
      cfg[1] = mk(0, 1, 5'd3); cfg[7] = mk(0, 1, 5'd12); cfg[4] = mk(0, 0, 5'd1);
      step(16'h0092); chk("R7 highest load wins", 5'd12, 5'd20);
      cfg[15] = mk(0, 0, 5'd5); cfg[0] = mk(0, 1, 5'd1);
      step(16'h8001); chk("R7 highest add wins", 5'd17, 5'd20);
   endtask

   task automatic t_indep;
      cfg[6] = mk(0, 1, 5'd2); cfg[9] = mk(1, 0, 5'd4); cfg[10] = mk(1, 1, 5'd1);
      step(16'h0640); chk("R8 independent arbitration", 5'd2, 5'd1);
      cfg[9] = mk(1, 0, 5'd4);
      step(16'h0240); chk("R8 low load with high add", 5'd2, 5'd5);
   endtask

   task automatic t_unify;
      unify = 1'b1;
      cfg[9] = mk(1, 1, 5'd25); cfg[3] = mk(0, 0, 5'd1);
      step(16'h0208); chk("R9 unified redirect", 5'd25, 5'd5);
      step(16'h0008); chk("R9 unified add", 5'd26, 5'd5);
      unify = 1'b0;
   endtask

   task automatic t_timing;
      cfg[8] = mk(0, 1, 5'd11);
      @(negedge clk); fire = 16'h0100;
      #1; chk("R10 no change before edge", 5'd26, 5'd5);
      @(posedge clk); #1; fire = '0;
      chk("R10 change at edge", 5'd11, 5'd5);
   endtask

   task automatic t_sync_reset;
      cfg[8] = mk(1, 1, 5'd3);
      @(negedge clk); rst = 1'b1; fire = 16'h0100;
      @(posedge clk); #1; fire = '0; rst = 1'b0;
      chk("R1 reset beats firing", 5'd0, 5'd0);
   endtask

   initial begin
      for (int i = 0; i < N; i++) cfg[i] = '0;
      repeat (3) @(posedge clk);
      #1; t_reset();
      @(negedge clk); rst = 1'b0;
      t_load_sel();
      t_add();
      t_prio();
      t_indep();
      t_unify();
      t_timing();
      t_sync_reset();
      repeat (2) @(posedge clk);
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #100000;
      if (!done) begin
         done = 1;
         errors++; checks++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule